// File: doc/BRIEF.md
# Clock-Control System Register Block

This block is the memory-mapped register file that holds the run-mode clock setup of a small system-control unit. Software writes a primary and a secondary clock configuration word. The block derives a system-clock period scale from whichever word is active and drives that scale on an output, so that timers elsewhere in the chip can follow clock changes. It also offers a read-only PLL setting that is looked up from the crystal-select field of the primary word. It holds three banks of peripheral clock-gating words, a brown-out control word, and a raw and masked interrupt status pair with one interrupt line.

A static device-class input picks the register set. The older class has no secondary clock word: that word reads zero, and writes to it are dropped. The newer class has the secondary word, and its top bit hands control of the divider to the secondary word's wider field. On the newer class, writing the secondary word so that its PLL power-down bit goes from set to clear raises a PLL-lock interrupt status bit.

Access is a single-cycle 32-bit port with a 12-bit byte offset. A write takes effect at the clock edge. Read data is combinational from the offset.

Top module: `sysclk_ctrl_regs`

## Requirements
- R1: After reset the primary clock word reads 0x078E3AC0 at offset 0x060 and brown-out control reads 0x7FFD at 0x030. Gating words 0 of the run bank (0x100), sleep bank (0x110) and deep-sleep bank (0x120) read 1, gating words 1 and 2 (offsets +4 and +8) read 0, and the mask (0x054) and raw status (0x050) read 0.
- R2: The secondary clock word sits at offset 0x070. On the newer class (class input 1) it resets to 0x07802810 and reads back the last value written to it.
- R3: While bit 31 of the secondary word is 0, the scale output equals 5 × (primary[26:23] + 1).
- R4: While bit 31 of the secondary word is 1, the scale output equals 5 × (secondary[28:23] + 1), covering the range 5 to 320.
- R5: A write to the secondary word on the newer class sets raw status bit 6 when the stored bit 13 is 1 and the written bit 13 is 0. No other write sets it.
- R6: On the older class (class input 0) the secondary word resets to 0, writes to it change nothing, and they never set raw status bit 6.
- R7: The interrupt output is high exactly when raw status AND mask is nonzero. Offset 0x058 reads that masked status, and writing 1s there clears the matching raw bits.
- R8: Offset 0x064 reads the PLL setting for index k = primary[9:6]. On the older class the value is {16'h0, 4'h3, 4'h0, k, 15-k}, and on the newer class it is {16'h0, 4'hB, 4'h0, k, 15-k}.
- R9: Reads of unmapped offsets return 0, and writes to them leave every register unchanged.
- R10: The brown-out word, the mask and all nine gating words read back the value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| newer_class | input | 1 | Device class: 1 newer (secondary word present), 0 older |
| wr_en | input | 1 | Write strobe for the current offset |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| clk_scale | output | 9 | System-clock period scale |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take the class input as constant between resets, and they take each access as one write or read to a single offset per cycle. The bench changes the class only while reset is held and applies a fresh reset after each change. It drives exactly one write per strobe cycle and deasserts the strobe before the next access, so the PLL edge rule and the write-one-to-clear rule are never exercised in the same cycle.

// File: rtl/sysclk_ctrl_regs.sv
module sysclk_ctrl_regs #(
  parameter int AW      = 12,
  parameter int DW      = 32,
  parameter int SCALE_W = 9,
  parameter int GATE_N  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          newer_class,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [SCALE_W-1:0] clk_scale,
  output logic          irq
);
  localparam logic [AW-1:0] A_BOR   = AW'('h030);
  localparam logic [AW-1:0] A_RAW   = AW'('h050);
  localparam logic [AW-1:0] A_MASK  = AW'('h054);
  localparam logic [AW-1:0] A_MSK   = AW'('h058);
  localparam logic [AW-1:0] A_CFG1  = AW'('h060);
  localparam logic [AW-1:0] A_PLL   = AW'('h064);
  localparam logic [AW-1:0] A_CFG2  = AW'('h070);
  localparam int RUN_BASE  = 'h100;
  localparam int SLP_BASE  = 'h110;
  localparam int DSL_BASE  = 'h120;
  localparam logic [DW-1:0] CFG1_RST = DW'('h078E3AC0);
  localparam logic [DW-1:0] CFG2_RST = DW'('h07802810);
  localparam logic [DW-1:0] BOR_RST  = DW'('h7FFD);
  localparam int PLL_BIT  = 13;
  localparam int LOCK_BIT = 6;

  logic [DW-1:0] cfg1_q, cfg2_q, bor_q, raw_q, mask_q;
  logic [DW-1:0] run_q [GATE_N];
  logic [DW-1:0] slp_q [GATE_N];
  logic [DW-1:0] dsl_q [GATE_N];

  function automatic logic [DW-1:0] pll_entry(input logic cls, input logic [3:0] k);
    return DW'({cls ? 4'hB : 4'h3, 4'h0, k, 4'(4'd15 - k)});
  endfunction

  logic [5:0] div_fld;
  assign div_fld   = cfg2_q[31] ? cfg2_q[28:23] : {2'b00, cfg1_q[26:23]};
  assign clk_scale = SCALE_W'(({3'b000, div_fld} + 9'd1) * 9'd5);
  assign irq       = |(raw_q & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg1_q <= CFG1_RST;
      cfg2_q <= newer_class ? CFG2_RST : '0;
      bor_q  <= BOR_RST;
      raw_q  <= '0;
      mask_q <= '0;
      for (int i = 0; i < GATE_N; i++) begin
        run_q[i] <= (i == 0) ? DW'(1) : '0;
        slp_q[i] <= (i == 0) ? DW'(1) : '0;
        dsl_q[i] <= (i == 0) ? DW'(1) : '0;
      end
    end else if (wr_en) begin
      case (addr)
        A_BOR:  bor_q  <= wdata;
        A_MASK: mask_q <= wdata;
        A_MSK:  raw_q  <= raw_q & ~wdata;
        A_CFG1: cfg1_q <= wdata;
        A_CFG2: if (newer_class) begin
          if (cfg2_q[PLL_BIT] && !wdata[PLL_BIT]) raw_q[LOCK_BIT] <= 1'b1;
          cfg2_q <= wdata;
        end
        default: ;
      endcase
      for (int i = 0; i < GATE_N; i++) begin
        if (addr == AW'(RUN_BASE + 4*i)) run_q[i] <= wdata;
        if (addr == AW'(SLP_BASE + 4*i)) slp_q[i] <= wdata;
        if (addr == AW'(DSL_BASE + 4*i)) dsl_q[i] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_BOR:  rdata = bor_q;
      A_RAW:  rdata = raw_q;
      A_MASK: rdata = mask_q;
      A_MSK:  rdata = raw_q & mask_q;
      A_CFG1: rdata = cfg1_q;
      A_PLL:  rdata = pll_entry(newer_class, cfg1_q[9:6]);
      A_CFG2: rdata = cfg2_q;
      default: ;
    endcase
    for (int i = 0; i < GATE_N; i++) begin
      if (addr == AW'(RUN_BASE + 4*i)) rdata = run_q[i];
      if (addr == AW'(SLP_BASE + 4*i)) rdata = slp_q[i];
      if (addr == AW'(DSL_BASE + 4*i)) rdata = dsl_q[i];
    end
  end

  // R6
  old_cfg2_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CFG2 && !newer_class) |=> ($stable(cfg2_q) && $stable(raw_q)));

  // R5
  pll_lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CFG2 && newer_class && cfg2_q[PLL_BIT] && !wdata[PLL_BIT])
    |=> raw_q[LOCK_BIT]);

  // R5
  pll_lock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q[LOCK_BIT]) |-> ($past(wr_en) && $past(addr) == A_CFG2));

  // R7
  irq_masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MASK && wdata == '0) |=> !irq);

  // R7
  raw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MSK && wdata[LOCK_BIT]) |=> !raw_q[LOCK_BIT]);

  // R4
  scale_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_scale >= SCALE_W'(5)) && (clk_scale <= SCALE_W'(320)) && (clk_scale % 5 == 0));

  // R9
  unmapped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[11:8] == 4'h2) |=> ($stable(cfg1_q) && $stable(cfg2_q) && $stable(mask_q)
      && $stable(bor_q)));
endmodule

// File: tb/sysclk_ctrl_regs_tb.sv
module sysclk_ctrl_regs_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic newer_class = 1'b1;
  logic wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [8:0] clk_scale;
  logic irq;
  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sysclk_ctrl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .newer_class(newer_class), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .clk_scale(clk_scale), .irq(irq)
  );

  // {offset, data, expected scale}, newer class
  localparam logic [52:0] VEC [7] = '{
    {12'h060, 32'h0000_0000, 9'd5},
    {12'h060, 32'h0780_0000, 9'd80},
    {12'h060, 32'h0100_0000, 9'd15},
    {12'h070, 32'h8000_0000, 9'd5},
    {12'h070, 32'h9F80_0000, 9'd320},
    {12'h070, 32'h8280_0000, 9'd30},
    {12'h070, 32'h0F80_0000, 9'd15}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic do_reset(input logic cls);
    @(negedge clk);
    rst_n = 1'b0; newer_class = cls;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [31:0] pll_exp(input logic cls, input logic [3:0] k);
    return {16'h0, cls ? 4'hB : 4'h3, 4'h0, k, 4'd15 - k};
  endfunction

  initial begin
    logic [31:0] v;
    do_reset(1'b1);
    // R1 reset state
    rd(12'h060, v); check("R1 cfg1", v, 32'h078E3AC0);
    rd(12'h030, v); check("R1 bor", v, 32'h7FFD);
    for (int b = 0; b < 3; b++) begin
      for (int i = 0; i < 3; i++) begin
        rd(12'(12'h100 + 16*b + 4*i), v); check("R1 gate", v, (i == 0) ? 32'd1 : 32'd0);
      end
    end
    rd(12'h054, v); check("R1 mask", v, 0);
    rd(12'h050, v); check("R1 raw", v, 0);
    check("R3 reset scale", 32'(clk_scale), 80);
    check("R1 irq", 32'(irq), 0);
    // R2
    rd(12'h070, v); check("R2 cfg2 reset", v, 32'h07802810);
    // R8 at reset: index 11
    rd(12'h064, v); check("R8 newer pll", v, pll_exp(1'b1, 4'd11));

    // R3 / R4 vector walk
    foreach (VEC[i]) begin
      wr(VEC[i][52:41], VEC[i][40:9]);
      check(VEC[i][52:41] == 12'h060 ? "R3 scale" : "R4 scale", 32'(clk_scale), 32'(VEC[i][8:0]));
    end
    rd(12'h070, v); check("R2 cfg2 readback", v, 32'h0F80_0000);

    // R5: first cfg2 write in the walk cleared bit 13 from reset value
    rd(12'h050, v); check("R5 lock raised", v, 32'h40);
    check("R7 irq masked", 32'(irq), 0);
    wr(12'h054, 32'h40);
    check("R7 irq on", 32'(irq), 1);
    rd(12'h058, v); check("R7 masked status", v, 32'h40);
    wr(12'h058, 32'h40);
    check("R7 clear irq", 32'(irq), 0);
    rd(12'h050, v); check("R7 raw cleared", v, 0);
    // R5: bit13 0->0 and 0->1 do not raise; 1->0 does
    wr(12'h070, 32'h0000_2000);
    rd(12'h050, v); check("R5 no set on 0->1", v, 0);
    wr(12'h070, 32'h0000_2000);
    rd(12'h050, v); check("R5 no set on 1->1", v, 0);
    wr(12'h070, 32'h0000_0000);
    check("R5 irq after edge", 32'(irq), 1);

    // R10
    wr(12'h030, 32'h1234_5678); rd(12'h030, v); check("R10 bor", v, 32'h1234_5678);
    wr(12'h128, 32'hA5A5_0001); rd(12'h128, v); check("R10 gate", v, 32'hA5A5_0001);
    // R8 other index
    wr(12'h060, 32'h0000_0140); rd(12'h064, v); check("R8 idx5", v, pll_exp(1'b1, 4'd5));
    // R9
    wr(12'h204, 32'hFFFF_FFFF);
    rd(12'h204, v); check("R9 unmapped read", v, 0);
    rd(12'h060, v); check("R9 cfg1 kept", v, 32'h0000_0140);
    rd(12'h030, v); check("R9 bor kept", v, 32'h1234_5678);

    // R6 older class
    do_reset(1'b0);
    rd(12'h070, v); check("R6 cfg2 reset", v, 0);
    wr(12'h070, 32'h9F80_0000);
    rd(12'h070, v); check("R6 write ignored", v, 0);
    check("R6 scale from cfg1", 32'(clk_scale), 80);
    rd(12'h050, v); check("R6 no lock", v, 0);
    rd(12'h064, v); check("R8 older pll", v, pll_exp(1'b0, 4'd11));

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule